// File: doc/BRIEF.md
# Serial ADC Bring-up and Readout Sequencer

This block is the host-side controller for an external three-channel sigma-delta converter. The converter is attached through a four-wire synchronous serial link and a data-ready line. A `start` pulse makes the sequencer bring the converter up with a fixed series of byte writes. Every register access first needs a write to the converter's communications register, which selects the channel and the register for the next access. The sequencer writes that byte and the clock-register byte, then that byte again and the setup-register byte. The last byte starts a self-calibration.

The sequencer then enters a read loop. It waits until the synchronized, active-low data-ready line is low. It then sends a communications byte that requests a read of the 16-bit data register and clocks the result in as a separate 16-bit frame. Each result appears on a parallel output with a one-cycle strobe. When the configured number of samples has been collected, `done` pulses and the sequencer goes back to idle, ready for the next `start`.

All byte values and the sample count are parameters. The serial clock is derived from the system clock by a parameterised half-period divider. A check at elaboration rejects any setting whose serial clock would exceed 3 MHz.

Top module: `adc_seq_top`

## Requirements
- R1: While and after reset, `cs_n`=1, `sclk`=1, `mosi`=1, `sample_valid`=0 and `done`=0 until `start` is seen.
- R2: After `start`, exactly four 8-bit frames come first, in this order: 0x20 (comms: write, channel 1, next target clock register), 0x0C (clock: divide-by-two set, 50 Hz rate), 0x10 (comms: write, channel 1, next target setup register), 0x40 (setup: self-calibration, gain 1, bipolar, buffer off, filter sync cleared).
- R3: Each word is shifted most-significant bit first. `mosi` changes only on falling `sclk` edges, and `miso` is sampled on rising `sclk` edges.
- R4: `sclk` idles high and is low only while `cs_n` is low.
- R5: Every `sclk` edge, and the first falling edge after `cs_n` falls, is exactly `HALF_DIV` clock cycles after the previous event. Elaboration fails if `CLK_HZ/(2*HALF_DIV)` exceeds 3 MHz.
- R6: Between two frames, `cs_n` stays high for at least 2*`HALF_DIV` clock cycles (one `sclk` period).
- R7: A read-command frame (byte 0x38: comms, read, data register, channel 1) starts only after `drdy_n` has been low for at least two clock cycles and is still low.
- R8: Each read is the 0x38 frame followed by a 16-bit frame during which `mosi` stays 1. The 16 bits received, MSB first, appear on `sample_data` with `sample_valid` high for exactly one cycle.
- R9: Exactly `NUM_SAMPLES` results are delivered per run (default 1000). `done` pulses for one cycle together with the last `sample_valid`. A `start` given while a run is in progress is ignored.
- R10: A `start` after `done` repeats the whole bring-up and read sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a bring-up and readout run (ignored while busy) |
| done | output | 1 | One-cycle pulse when the last sample is delivered |
| sclk | output | 1 | Serial clock to the converter, idles high |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select, low for each frame |
| drdy_n | input | 1 | Active-low data-ready from the converter (asynchronous) |
| sample_data | output | 16 | Last conversion result |
| sample_valid | output | 1 | One-cycle strobe for `sample_data` |

## Verification
The assertions check the pin-level rules on every cycle:
- `sclk` is never low outside a frame.
- `mosi` is stable across each rising edge.
- A frame starts only from idle.
- The synchronizer's output falls only after its input was low two cycles earlier.
- The result strobe and `done` are single pulses that arrive together at the end.
- The sample counter stays in range.

Only the bench scenarios can show the rest: the byte values and their order, the exact `sclk` timing, the chip-select gap, read gating under short, zero and long data-ready delays, the received words matching what the converter model sent, a `start` ignored mid-run, and a second run repeating the sequence.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CFG,
    ST_POLL,
    ST_RDCMD,
    ST_RDDAT
  } seq_state_t;

  typedef enum logic [2:0] {
    F_IDLE,
    F_LEAD,
    F_LOW,
    F_HIGH,
    F_TAIL,
    F_GAP1,
    F_GAP2
  } frame_state_t;

  localparam int CFG_WORDS = 4;
  localparam int WORD_W    = 16;
endpackage

// File: rtl/adc_seq_drdy_sync.sv
module adc_seq_drdy_sync (
  input  logic clk,
  input  logic rst,
  input  logic drdy_n_in,
  output logic drdy_n_sync
);
  logic [1:0] stages;

  always_ff @(posedge clk) begin
    if (rst) stages <= 2'b11;
    else     stages <= {stages[0], drdy_n_in};
  end

  assign drdy_n_sync = stages[1];

  // R7: synchronized ready may only fall after the raw line was low two cycles back
  a_r7_sync_latency: assert property (@(posedge clk) disable iff (rst)
    $fell(drdy_n_sync) |-> $past(!drdy_n_in, 2));
endmodule

// File: rtl/adc_seq_frame.sv
module adc_seq_frame
  import adc_seq_pkg::*;
#(
  parameter int HALF_DIV = 42
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic                long_frame,
  input  logic [WORD_W-1:0]   tx_word,
  input  logic                miso,
  output logic                sclk,
  output logic                cs_n,
  output logic                mosi,
  output logic [WORD_W-1:0]   rx_word,
  output logic                frame_done
);
  localparam int HW = $clog2(HALF_DIV + 1);
  localparam logic [HW-1:0] HALF_LAST = HW'(HALF_DIV - 1);

  frame_state_t      st;
  logic [HW-1:0]     hcnt;
  logic [4:0]        bitn;
  logic [4:0]        last_idx;
  logic [WORD_W-1:0] sh;
  logic              tick;

  assign tick = (hcnt == HALF_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= F_IDLE;
      hcnt       <= '0;
      bitn       <= '0;
      last_idx   <= 5'd7;
      sh         <= '1;
      sclk       <= 1'b1;
      cs_n       <= 1'b1;
      mosi       <= 1'b1;
      rx_word    <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (st == F_IDLE || tick) hcnt <= '0;
      else                      hcnt <= hcnt + 1'b1;

      case (st)
        F_IDLE: if (go) begin
          st       <= F_LEAD;
          cs_n     <= 1'b0;
          sh       <= tx_word;
          bitn     <= '0;
          last_idx <= long_frame ? 5'd15 : 5'd7;
        end
        F_LEAD, F_HIGH: if (tick) begin
          sclk <= 1'b0;
          mosi <= sh[WORD_W-1];
          sh   <= {sh[WORD_W-2:0], 1'b1};
          st   <= F_LOW;
        end
        F_LOW: if (tick) begin
          sclk    <= 1'b1;
          rx_word <= {rx_word[WORD_W-2:0], miso};
          bitn    <= bitn + 1'b1;
          st      <= (bitn == last_idx) ? F_TAIL : F_HIGH;
        end
        F_TAIL: if (tick) begin
          cs_n <= 1'b1;
          mosi <= 1'b1;
          st   <= F_GAP1;
        end
        F_GAP1: if (tick) st <= F_GAP2;
        F_GAP2: if (tick) begin
          st         <= F_IDLE;
          frame_done <= 1'b1;
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  // R4: serial clock low only inside a frame
  a_r4_sclk_idle_high: assert property (@(posedge clk) disable iff (rst)
    !sclk |-> !cs_n);
  // R3: data never moves on a rising edge
  a_r3_mosi_stable_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(mosi));
  // R6: a new frame is requested only after the previous gap has ended
  a_r6_go_when_idle: assert property (@(posedge clk) disable iff (rst)
    go |-> st == F_IDLE);
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int          CLK_HZ      = 250_000_000,
  parameter int          HALF_DIV    = 42,
  parameter int          NUM_SAMPLES = 1000,
  parameter logic [7:0]  COMM_CLK    = 8'h20,
  parameter logic [7:0]  CLK_BYTE    = 8'h0C,
  parameter logic [7:0]  COMM_SETUP  = 8'h10,
  parameter logic [7:0]  SETUP_BYTE  = 8'h40,
  parameter logic [7:0]  COMM_READ   = 8'h38
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic        done,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n,
  input  logic        drdy_n,
  output logic [15:0] sample_data,
  output logic        sample_valid
);
  localparam int CW = $clog2(NUM_SAMPLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(NUM_SAMPLES - 1);
  localparam int MAX_SCLK_HZ = 3_000_000;

  initial begin
    if (HALF_DIV < 1 || NUM_SAMPLES < 1)
      $error("adc_seq_top: HALF_DIV and NUM_SAMPLES must be positive");
    if (CLK_HZ / (2 * HALF_DIV) > MAX_SCLK_HZ)
      $error("adc_seq_top: serial clock above 3 MHz, raise HALF_DIV");
  end

  seq_state_t        state;
  logic [1:0]        cfg_idx;
  logic [CW-1:0]     cnt;
  logic              wait_f;
  logic              go;
  logic              long_frame;
  logic [WORD_W-1:0] tx_word;
  logic [WORD_W-1:0] rx_word;
  logic              frame_done;
  logic              drdy_s;
  logic [7:0]        cfg_byte;

  always_comb begin
    case (cfg_idx)
      2'd0:    cfg_byte = COMM_CLK;
      2'd1:    cfg_byte = CLK_BYTE;
      2'd2:    cfg_byte = COMM_SETUP;
      default: cfg_byte = SETUP_BYTE;
    endcase
  end

  adc_seq_drdy_sync u_sync (
    .clk         (clk),
    .rst         (rst),
    .drdy_n_in   (drdy_n),
    .drdy_n_sync (drdy_s)
  );

  adc_seq_frame #(.HALF_DIV(HALF_DIV)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .long_frame (long_frame),
    .tx_word    (tx_word),
    .miso       (miso),
    .sclk       (sclk),
    .cs_n       (cs_n),
    .mosi       (mosi),
    .rx_word    (rx_word),
    .frame_done (frame_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cfg_idx      <= '0;
      cnt          <= '0;
      wait_f       <= 1'b0;
      go           <= 1'b0;
      long_frame   <= 1'b0;
      tx_word      <= '1;
      sample_data  <= '0;
      sample_valid <= 1'b0;
      done         <= 1'b0;
    end else begin
      go           <= 1'b0;
      sample_valid <= 1'b0;
      done         <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_CFG;
          cfg_idx <= '0;
          cnt     <= '0;
          wait_f  <= 1'b0;
        end
        ST_CFG: begin
          if (!wait_f) begin
            go         <= 1'b1;
            long_frame <= 1'b0;
            tx_word    <= {cfg_byte, 8'hFF};
            wait_f     <= 1'b1;
          end else if (frame_done) begin
            wait_f <= 1'b0;
            if (cfg_idx == 2'(CFG_WORDS - 1)) state <= ST_POLL;
            else cfg_idx <= cfg_idx + 1'b1;
          end
        end
        ST_POLL: if (!drdy_s) state <= ST_RDCMD;
        ST_RDCMD: begin
          if (!wait_f) begin
            go         <= 1'b1;
            long_frame <= 1'b0;
            tx_word    <= {COMM_READ, 8'hFF};
            wait_f     <= 1'b1;
          end else if (frame_done) begin
            wait_f <= 1'b0;
            state  <= ST_RDDAT;
          end
        end
        ST_RDDAT: begin
          if (!wait_f) begin
            go         <= 1'b1;
            long_frame <= 1'b1;
            tx_word    <= '1;
            wait_f     <= 1'b1;
          end else if (frame_done) begin
            wait_f       <= 1'b0;
            sample_data  <= rx_word;
            sample_valid <= 1'b1;
            if (cnt == CNT_LAST) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              cnt   <= cnt + 1'b1;
              state <= ST_POLL;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: result strobe lasts one cycle
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);
  // R9: completion coincides with the final result
  a_r9_done_with_last: assert property (@(posedge clk) disable iff (rst)
    done |-> sample_valid);
  // R9: completion is a single pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9: sample counter never passes the programmed count
  a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(NUM_SAMPLES));
endmodule

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;
  localparam int HALF = 2;
  localparam int NS   = 6;
  localparam int FR_PER_RUN = 4 + 2 * NS;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        miso = 1'b0;
  logic        drdy_n = 1'b1;
  logic        done, sclk, mosi, cs_n, sample_valid;
  logic [15:0] sample_data;

  always #2 clk = ~clk;

  adc_seq_top #(.CLK_HZ(12_000_000), .HALF_DIV(HALF), .NUM_SAMPLES(NS)) u_dut (
    .clk(clk), .rst(rst), .start(start), .done(done), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n), .drdy_n(drdy_n), .sample_data(sample_data),
    .sample_valid(sample_valid)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int pick_delay(input int mode);
    if (mode == 1) return 1;
    if (mode == 2) return 300;
    return 1 + int'($urandom % 40);
  endfunction

  // main-owned controls
  bit mon_en = 1'b0;
  int dly_mode = 0;
  int arm_req = 0;

  // monitor-owned state
  int arm_ack = 0, drdy_cnt = 0, drdy_low_cyc = -100;
  bit p_cs = 1'b1, p_sclk = 1'b1;
  int edge_cyc = 0, rise_cyc = -100, nb = 0, nfr = 0;
  logic [15:0] cap, sh_out, data_word;
  bit data_next = 1'b0, cur_data = 1'b0, drdy_ok_at_fall = 1'b0;
  logic [15:0] fr_val [0:63];
  int fr_bits [0:63];
  bit fr_drdy [0:63];
  logic [15:0] exp_q [$];
  int n_valid = 0, n_done = 0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (arm_req != arm_ack) begin
        arm_ack = arm_req; drdy_n = 1'b1; drdy_cnt = pick_delay(dly_mode);
      end else if (drdy_cnt > 0) begin
        drdy_cnt--;
        if (drdy_cnt == 0) begin drdy_n = 1'b0; drdy_low_cyc = cyc; end
      end
      chk(!( cs_n && !sclk), "R4", "sclk low outside frame", {31'd0, sclk}, 32'd1);
      if (p_cs && !cs_n) begin
        chk(cyc - rise_cyc >= 2 * HALF, "R6", "cs_n high gap", cyc - rise_cyc, 2 * HALF);
        cap = '0; nb = 0; edge_cyc = cyc;
        drdy_ok_at_fall = (drdy_n == 1'b0) && (cyc >= drdy_low_cyc + 2);
        cur_data = data_next;
        sh_out = data_next ? data_word : 16'h0000;
      end
      if (!cs_n && sclk != p_sclk) begin
        chk(cyc - edge_cyc == HALF, "R5", "sclk half period", cyc - edge_cyc, HALF);
        edge_cyc = cyc;
        if (sclk) begin cap = {cap[14:0], mosi}; nb++; end
        else begin miso = sh_out[15]; sh_out = {sh_out[14:0], 1'b0}; end
      end
      if (!p_cs && cs_n) begin
        rise_cyc = cyc;
        if (nfr < 64) begin
          fr_val[nfr] = cap; fr_bits[nfr] = nb; fr_drdy[nfr] = drdy_ok_at_fall;
        end
        nfr++;
        if (cur_data) begin
          data_next = 1'b0; drdy_n = 1'b1; drdy_cnt = pick_delay(dly_mode);
        end else if (nb == 8 && cap[7:0] == 8'h38) begin
          data_next = 1'b1; data_word = 16'($urandom); exp_q.push_back(data_word);
        end
      end
      if (sample_valid) begin
        n_valid++;
        if (exp_q.size() == 0) chk(1'b0, "R8", "unexpected sample", {16'd0, sample_data}, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(sample_data == e, "R8", "sample word MSB first", {16'd0, sample_data}, {16'd0, e});
        end
      end
      if (done) begin
        n_done++;
        chk(sample_valid, "R9", "done with last sample", {31'd0, sample_valid}, 1);
      end
    end
    p_cs = cs_n; p_sclk = sclk;
  end

  task automatic finish_tb();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic run(input int mode, input bit mid_start);
    int base, v0, d0, lim;
    logic [7:0] cfg_exp [4];
    cfg_exp[0] = 8'h20; cfg_exp[1] = 8'h0C; cfg_exp[2] = 8'h10; cfg_exp[3] = 8'h40;
    base = nfr; v0 = n_valid; d0 = n_done;
    dly_mode = mode; arm_req++;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (mid_start) begin
      repeat (150) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    lim = 0;
    while (n_done == d0 && lim < 30000) begin @(negedge clk); lim++; end
    chk(n_done == d0 + 1, "R9", "done reached", n_done - d0, 1);
    repeat (40) @(negedge clk);
    chk(n_done == d0 + 1, "R9", "single done, mid-run start ignored", n_done - d0, 1);
    chk(n_valid - v0 == NS, "R9", "sample count", n_valid - v0, NS);
    chk(nfr - base == FR_PER_RUN, "R9", "frame count", nfr - base, FR_PER_RUN);
    chk(exp_q.size() == 0, "R8", "all words delivered", exp_q.size(), 0);
    for (int i = 0; i < 4; i++) begin
      chk(fr_bits[base+i] == 8, "R2", "config frame length", fr_bits[base+i], 8);
      chk(fr_val[base+i][7:0] == cfg_exp[i], "R2", "config byte order (R3 MSB first)",
          {24'd0, fr_val[base+i][7:0]}, {24'd0, cfg_exp[i]});
    end
    for (int k = 0; k < NS; k++) begin
      int c = base + 4 + 2 * k;
      chk(fr_val[c][7:0] == 8'h38 && fr_bits[c] == 8, "R8", "read command byte",
          {24'd0, fr_val[c][7:0]}, 32'h38);
      chk(fr_drdy[c], "R7", "read gated by drdy_n low", {31'd0, fr_drdy[c]}, 1);
      chk(fr_bits[c+1] == 16 && fr_val[c+1] == 16'hFFFF, "R8", "data frame length and idle mosi",
          {16'd0, fr_val[c+1]}, 32'hFFFF);
    end
    chk(cs_n && sclk, "R4", "idle after run", {30'd0, cs_n, sclk}, 3);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    chk(cs_n == 1'b1, "R1", "cs_n in reset", {31'd0, cs_n}, 1);
    chk(sclk == 1'b1, "R1", "sclk in reset", {31'd0, sclk}, 1);
    chk(mosi == 1'b1, "R1", "mosi in reset", {31'd0, mosi}, 1);
    chk(!sample_valid && !done, "R1", "strobes in reset", {30'd0, sample_valid, done}, 0);
    rst = 1'b0;
    p_cs = cs_n; p_sclk = sclk;
    mon_en = 1'b1;
    repeat (20) @(negedge clk);
    chk(cs_n && !done, "R1", "idle without start", {30'd0, cs_n, done}, 2);
    run(0, 1'b1);   // random drdy delays, stray start mid-run
    run(1, 1'b0);   // R10 repeat; drdy low almost at once
    run(2, 1'b0);   // R7 long wait on drdy
    finish_tb();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_tb();
  end
endmodule